// File: doc/BRIEF.md
# Calendar Timekeeper with Deferred Register Commit

This block keeps the time of day and the date, and advances by one second on each one-second tick. Software sees three words on a small register bus: a control word, a packed date word and a packed time word. A register write is not applied at once. The value is held, a busy flag in the control word goes high, and the counter takes the value only on the second tick after the write. Software polls the flag before it writes the same register again. A write to a register whose flag is still high is dropped.

A parameter picks how the date is kept. In calendar mode the date word holds the day of the month, the month, the year as an offset from 1970, and a leap-year flag. In linear mode the date word holds a plain 16-bit day count. When the clock passes midnight, the block drives a one-cycle pulse.

Each of the two writable words has its own commit state machine with three states. `CM_IDLE` moves to `CM_HOLD1` on an accepted write. `CM_HOLD1` moves to `CM_HOLD2` on a tick. `CM_HOLD2` returns to `CM_IDLE` on the next tick, and that tick loads the held value into the counter. The busy flag is high in every state except `CM_IDLE`.

Top module: `cal_timekeeper`

## Requirements
- R1: After reset the control word reads 0, the time word reads 0 and the date word reads 0x00000101 (1970-01-01, leap flag 0) in calendar mode or 0 in linear mode. The day pulse is low.
- R2: The time word holds seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16, with all other bits zero. Each tick that does not commit a time write advances it by one second. Seconds wrap after 59 and carry into minutes, minutes wrap after 59 and carry into hours, and hours wrap after 23.
- R3: A write to offset 0x14 sets control bit 8. The time counter keeps counting from its old value for one tick. On the second tick after the write it takes the written value instead of advancing, and bit 8 clears on that same edge.
- R4: A write to offset 0x10 sets control bit 7. The date is loaded on the second tick after the write, and bit 7 clears on that same edge.
- R5: A write to the time or date word while its busy bit is set is ignored. The value committed is the one from the first write.
- R6: The tick that takes the time from 23:59:59 to 00:00:00 advances the date by one day and raises the day pulse for exactly one clock cycle after that edge.
- R7: In calendar mode the date word holds the day in bits 4:0, the month (1 to 12) in bits 11:8, the year offset in bits 21:16 and the leap flag in bit 22. April, June, September and November end after day 30. February ends after day 29 when the leap flag is 1 and after day 28 otherwise. All other months end after day 31. The day after the last day is day 1 of the next month.
- R8: The day after December 31 is January 1 of the next year offset. The leap flag is then recomputed as 1 exactly when offset + 1970 is divisible by 4.
- R9: The last instant of the range is offset 63 (2033), December 31, 23:59:59. The next tick gives 1970-01-01 00:00:00 with leap flag 0.
- R10: In linear mode only bits 15:0 of the date word are stored, and the other bits read zero. The count increases by one at each day rollover and wraps from 0xFFFF to 0.
- R11: The control word reads zero outside bits 8 and 7, and offsets other than 0x00, 0x10 and 0x14 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the word at bus_addr, combinational |
| day_pulse | output | 1 | High for one cycle after a midnight rollover |

## Verification
The bench sweeps one full hour of ticks across midnight and computes every expected time word from the elapsed seconds, so a wrong carry limit shows up as a drift. It also sets the last day of every month in a leap year and in a common year, and the last day of every year offset from 0 to 63. A month-length table that is off by one, or a leap flag computed from the wrong year, lands on the wrong date. A wrong wrap at 2033 gives a year other than 1970. The busy sequence checks that the old time keeps running through the first tick and that a second write made while busy is dropped. A design that commits on the first tick, or that takes the later value, fails these checks. In linear mode the bench checks the wrap from 0xFFFF to 0 and that the upper bits are masked.

// File: rtl/tk_pkg.sv
package tk_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HR_W   = 5;
    localparam int DAY_W  = 5;
    localparam int MON_W  = 4;
    localparam int YR_W   = 6;
    localparam int LIN_W  = 16;
    localparam int WORD_W = 32;

    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(59);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(59);
    localparam logic [HR_W-1:0]  HR_LAST  = HR_W'(23);
    localparam logic [MON_W-1:0] MON_LAST = MON_W'(12);
    localparam logic [YR_W-1:0]  YR_LAST  = {YR_W{1'b1}};

    localparam int CH_DATE = 0;
    localparam int CH_TIME = 1;
    localparam int N_CH    = 2;

    typedef enum logic [1:0] {
        CM_IDLE  = 2'd0,
        CM_HOLD1 = 2'd1,
        CM_HOLD2 = 2'd2
    } commit_state_t;

    function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] m,
                                                   input logic leap);
        case (m)
            MON_W'(2):                          return leap ? DAY_W'(29) : DAY_W'(28);
            MON_W'(4), MON_W'(6), MON_W'(9),
            MON_W'(11):                         return DAY_W'(30);
            default:                            return DAY_W'(31);
        endcase
    endfunction

    function automatic logic leap_of(input logic [YR_W-1:0] yoff);
        // offset + 1970 divisible by 4 <=> offset mod 4 == 2
        return yoff[1:0] == 2'd2;
    endfunction

endpackage

// File: rtl/tk_commit_fsm.sv
module tk_commit_fsm
    import tk_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_req,
    input  logic [W-1:0] wr_data,
    output logic         busy,
    output logic         load,
    output logic [W-1:0] held
);

    commit_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CM_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CM_IDLE:  if (wr_req) nxt = CM_HOLD1;
            CM_HOLD1: if (tick)   nxt = CM_HOLD2;
            CM_HOLD2: if (tick)   nxt = CM_IDLE;
            default:              nxt = CM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          held <= '0;
        else if (state == CM_IDLE && wr_req) held <= wr_data;
    end

    always_comb begin
        busy = (state != CM_IDLE);
        load = (state == CM_HOLD2) && tick;
    end

    p_busy_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_req) |=> busy);
    p_drop_when_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_req) |=> $stable(held));
    p_clear_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !busy);

endmodule

// File: rtl/tk_hms_counter.sv
module tk_hms_counter
    import tk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    output logic [WORD_W-1:0] time_word,
    output logic              day_carry
);

    logic [SEC_W-1:0] sec;
    logic [MIN_W-1:0] mnt;
    logic [HR_W-1:0]  hr;
    logic sec_end, min_end, hr_end;

    logic unused_tbits;
    assign unused_tbits = ^{load_word[31:21], load_word[15:14], load_word[7:6]};

    always_comb begin
        sec_end   = (sec >= SEC_LAST);
        min_end   = (mnt >= MIN_LAST);
        hr_end    = (hr  >= HR_LAST);
        day_carry = tick && !load && sec_end && min_end && hr_end;
        time_word = {11'd0, hr, 2'd0, mnt, 2'd0, sec};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec <= '0;
            mnt <= '0;
            hr  <= '0;
        end else if (load) begin
            sec <= load_word[5:0];
            mnt <= load_word[13:8];
            hr  <= load_word[20:16];
        end else if (tick) begin
            if (!sec_end) begin
                sec <= sec + 1'b1;
            end else begin
                sec <= '0;
                if (!min_end) begin
                    mnt <= mnt + 1'b1;
                end else begin
                    mnt <= '0;
                    hr  <= hr_end ? '0 : hr + 1'b1;
                end
            end
        end
    end

    p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && sec < SEC_LAST) |=> sec == $past(sec) + SEC_W'(1));
    p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && sec == SEC_LAST) |=> sec == '0);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(time_word));

endmodule

// File: rtl/tk_date_counter.sv
module tk_date_counter
    import tk_pkg::*;
#(
    parameter bit LINEAR_DAY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              day_inc,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    output logic [WORD_W-1:0] date_word
);

    generate
        if (LINEAR_DAY) begin : g_linear
            logic [LIN_W-1:0] cnt;
            logic unused_dbits;
            assign unused_dbits = ^load_word[WORD_W-1:LIN_W];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       cnt <= '0;
                else if (load)    cnt <= load_word[LIN_W-1:0];
                else if (day_inc) cnt <= cnt + 1'b1;
            end

            assign date_word = {{(WORD_W-LIN_W){1'b0}}, cnt};

            p_lin_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (day_inc && !load) |=> cnt == LIN_W'($past(cnt) + 1'b1));
        end else begin : g_calendar
            logic [DAY_W-1:0] day;
            logic [MON_W-1:0] mon;
            logic [YR_W-1:0]  yr;
            logic             leap;
            logic [DAY_W-1:0] mlen;
            logic [YR_W-1:0]  yr_next;
            logic             mon_end, yr_end;
            logic unused_dbits;
            assign unused_dbits = ^{load_word[31:23], load_word[15:12], load_word[7:5]};

            always_comb begin
                mlen    = month_len(mon, leap);
                mon_end = (day >= mlen);
                yr_end  = (mon >= MON_LAST);
                yr_next = (yr == YR_LAST) ? '0 : yr + 1'b1;
                date_word = {9'd0, leap, yr, 4'd0, mon, 3'd0, day};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    day  <= DAY_W'(1);
                    mon  <= MON_W'(1);
                    yr   <= '0;
                    leap <= 1'b0;
                end else if (load) begin
                    day  <= load_word[4:0];
                    mon  <= load_word[11:8];
                    yr   <= load_word[21:16];
                    leap <= load_word[22];
                end else if (day_inc) begin
                    if (!mon_end) begin
                        day <= day + 1'b1;
                    end else begin
                        day <= DAY_W'(1);
                        if (!yr_end) begin
                            mon <= mon + 1'b1;
                        end else begin
                            mon  <= MON_W'(1);
                            yr   <= yr_next;
                            leap <= leap_of(yr_next);
                        end
                    end
                end
            end

            p_day_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (day_inc && !load && !mon_end) |=> day == $past(day) + DAY_W'(1));
            p_month_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (day_inc && !load && mon_end) |=> day == DAY_W'(1));
            p_leap_recalc_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (day_inc && !load && mon_end && yr_end) |=> leap == (yr[1:0] == 2'd2));
        end
    endgenerate

endmodule

// File: rtl/cal_timekeeper.sv
module cal_timekeeper
    import tk_pkg::*;
#(
    parameter bit                LINEAR_DAY = 1'b0,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS   = ADDR_W'('h00),
    parameter logic [ADDR_W-1:0] DATE_OFS   = ADDR_W'('h10),
    parameter logic [ADDR_W-1:0] TIME_OFS   = ADDR_W'('h14)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              day_pulse
);

    localparam int TIME_BUSY_BIT = 8;
    localparam int DATE_BUSY_BIT = 7;

    logic [N_CH-1:0]        wr_req;
    logic [N_CH-1:0]        busy;
    logic [N_CH-1:0]        load;
    logic [WORD_W-1:0]      held [N_CH];
    logic [WORD_W-1:0]      time_word, date_word, ctrl_word;
    logic                   day_carry;

    always_comb begin
        wr_req[CH_DATE] = bus_wr && (bus_addr == DATE_OFS);
        wr_req[CH_TIME] = bus_wr && (bus_addr == TIME_OFS);
    end

    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_commit
            tk_commit_fsm #(.W(WORD_W)) u_commit (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (sec_tick),
                .wr_req  (wr_req[ch]),
                .wr_data (bus_wdata),
                .busy    (busy[ch]),
                .load    (load[ch]),
                .held    (held[ch])
            );
        end
    endgenerate

    tk_hms_counter u_hms (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sec_tick),
        .load      (load[CH_TIME]),
        .load_word (held[CH_TIME]),
        .time_word (time_word),
        .day_carry (day_carry)
    );

    tk_date_counter #(.LINEAR_DAY(LINEAR_DAY)) u_date (
        .clk       (clk),
        .rst_n     (rst_n),
        .day_inc   (day_carry),
        .load      (load[CH_DATE]),
        .load_word (held[CH_DATE]),
        .date_word (date_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) day_pulse <= 1'b0;
        else        day_pulse <= day_carry;
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[TIME_BUSY_BIT] = busy[CH_TIME];
        ctrl_word[DATE_BUSY_BIT] = busy[CH_DATE];
        if (bus_addr == CTRL_OFS)      bus_rdata = ctrl_word;
        else if (bus_addr == DATE_OFS) bus_rdata = date_word;
        else if (bus_addr == TIME_OFS) bus_rdata = time_word;
        else                           bus_rdata = '0;
    end

    p_pulse_midnight_r6: assert property (@(posedge clk) disable iff (!rst_n)
        day_pulse |-> time_word == '0);
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        day_pulse |=> !day_pulse);
    p_time_frozen_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[CH_TIME] && !sec_tick) |=> $stable(time_word));

endmodule

// File: tb/cal_timekeeper_tb.sv
`timescale 1ns/1ps
module cal_timekeeper_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_c = 1'b0;
    logic        wr_l = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rd_c, rd_l;
    logic        dp_c, dp_l;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cal_timekeeper #(.LINEAR_DAY(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(tick), .bus_wr(wr_c),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd_c), .day_pulse(dp_c));

    cal_timekeeper #(.LINEAR_DAY(1'b1)) dut_lin_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(tick), .bus_wr(wr_l),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd_l), .day_pulse(dp_l));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input bit lin, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (lin) wr_l = 1'b1; else wr_c = 1'b1;
        @(negedge clk);
        wr_c = 1'b0; wr_l = 1'b0;
    endtask

    task automatic rd(input bit lin, input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #0.5;
        v = lin ? rd_l : rd_c;
    endtask

    task automatic tick1();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic set_all(input bit lin, input logic [31:0] d, input logic [31:0] t);
        wr(lin, 8'h14, t);
        wr(lin, 8'h10, d);
        tick1();
        tick1();
    endtask

    function automatic logic [31:0] cal_word(int lp, int yo, int m, int d);
        return (32'(lp) << 22) | (32'(yo) << 16) | (32'(m) << 8) | 32'(d);
    endfunction

    function automatic int mdays(int m, int lp);
        if (m == 2) return lp ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, 8'h00, v); chk("R1 ctrl", v, 32'h0);
        rd(0, 8'h14, v); chk("R1 time", v, 32'h0);
        rd(0, 8'h10, v); chk("R1 date", v, 32'h101);
        rd(1, 8'h10, v); chk("R1 linear date", v, 32'h0);
        chk("R1 pulse", {31'd0, dp_c}, 32'h0);
        // R11 unmapped offset
        rd(0, 8'h04, v); chk("R11 unmapped", v, 32'h0);

        // R3 / R5 time commit timing
        set_all(0, 32'h101, 32'h0);
        wr(0, 8'h14, 32'h0001_0203);
        rd(0, 8'h00, v); chk("R3 busy set", v, 32'h100);
        rd(0, 8'h14, v); chk("R3 old time held", v, 32'h0);
        wr(0, 8'h14, 32'h0005_0505);
        tick1();
        rd(0, 8'h00, v); chk("R3 busy after one tick", v, 32'h100);
        rd(0, 8'h14, v); chk("R3 old time counts", v, 32'h1);
        tick1();
        rd(0, 8'h00, v); chk("R3 busy cleared", v, 32'h0);
        rd(0, 8'h14, v); chk("R5 first value committed", v, 32'h0001_0203);

        // R4 / R5 date commit
        wr(0, 8'h10, 32'h0042_0305);
        rd(0, 8'h00, v); chk("R4 busy set", v, 32'h080);
        wr(0, 8'h10, 32'h0001_0101);
        tick1();
        rd(0, 8'h10, v); chk("R4 date not yet", v, 32'h101);
        tick1();
        rd(0, 8'h00, v); chk("R4 busy cleared", v, 32'h0);
        rd(0, 8'h10, v); chk("R5 date first value", v, 32'h0042_0305);
        rd(0, 8'h18, v); chk("R11 unmapped after use", v, 32'h0);

        // R2 / R6 one-hour sweep across midnight
        set_all(0, 32'h101, 32'h0017_0000);
        for (int i = 1; i <= 3600; i++) begin
            int t;
            tick1();
            t = (82800 + i) % 86400;
            rd(0, 8'h14, v);
            chk("R2 time sweep", v, (32'(t / 3600) << 16) | (32'((t / 60) % 60) << 8) | 32'(t % 60));
            chk("R6 pulse in sweep", {31'd0, dp_c}, (t == 0) ? 32'h1 : 32'h0);
        end
        rd(0, 8'h10, v); chk("R6 date advanced", v, 32'h102);
        @(negedge clk);
        chk("R6 pulse one cycle", {31'd0, dp_c}, 32'h0);

        // R7 month ends in a common and a leap year
        for (int lp = 0; lp < 2; lp++) begin
            for (int m = 1; m <= 12; m++) begin
                int yo, len, ny;
                logic [31:0] e;
                yo  = lp ? 2 : 1;
                len = mdays(m, lp);
                set_all(0, cal_word(lp, yo, m, len), 32'h0017_3B3B);
                tick1();
                if (m == 12) begin
                    ny = yo + 1;
                    e = cal_word(((ny + 1970) % 4 == 0) ? 1 : 0, ny, 1, 1);
                end else begin
                    e = cal_word(lp, yo, m + 1, 1);
                end
                rd(0, 8'h10, v); chk("R7 month end", v, e);
            end
        end
        set_all(0, cal_word(1, 2, 2, 28), 32'h0017_3B3B);
        tick1();
        rd(0, 8'h10, v); chk("R7 leap Feb 29", v, cal_word(1, 2, 2, 29));

        // R8 / R9 year sweep
        for (int yo = 0; yo < 64; yo++) begin
            int lp, ny;
            logic [31:0] e;
            lp = ((yo + 1970) % 4 == 0) ? 1 : 0;
            set_all(0, cal_word(lp, yo, 12, 31), 32'h0017_3B3B);
            tick1();
            if (yo == 63) begin
                e = 32'h101;
                rd(0, 8'h10, v); chk("R9 range wrap", v, e);
                rd(0, 8'h14, v); chk("R9 time wrap", v, 32'h0);
            end else begin
                ny = yo + 1;
                e = cal_word(((ny + 1970) % 4 == 0) ? 1 : 0, ny, 1, 1);
                rd(0, 8'h10, v); chk("R8 new year", v, e);
            end
        end

        // R10 linear day mode
        set_all(1, 32'hABCD_FFFF, 32'h0017_3B3B);
        rd(1, 8'h10, v); chk("R10 masked load", v, 32'h0000_FFFF);
        tick1();
        rd(1, 8'h10, v); chk("R10 wrap to zero", v, 32'h0);
        chk("R10 pulse", {31'd0, dp_l}, 32'h1);
        set_all(1, 32'h0000_0005, 32'h0017_3B3B);
        tick1();
        rd(1, 8'h10, v); chk("R10 step", v, 32'h6);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule